// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves 8-bit channels between serial time-division streams. It captures every channel arriving on each input stream into a data memory that is split in two by frame parity. Each output channel then reads the half that was filled during the previous frame, so every switched byte sees exactly one frame of delay. For each output stream and channel, a connection memory word chooses what the channel carries: a byte switched from any input stream and channel, a fixed message byte supplied by the processor, a byte from one of several pseudorandom test generators, or nothing at all (the output is released to high impedance).

A bit clock drives the block at the 4.096 Mbps bit rate, so one frame is 512 clocks. Each input and each output stream has its own rate select. A fast stream carries 64 channels with one bit per clock. A slow stream (2.048 Mbps) carries 32 channels with each bit held for two clocks. Bits travel most significant first. A frame sequencer with two states controls the whole block. `SEQ_HUNT` is entered at reset. The block leaves it for `SEQ_RUN` on the first frame pulse. In `SEQ_RUN` the sequencer stays put: a later frame pulse, or the count wrapping, restarts the frame and flips the buffer parity. A simple register port writes and reads the connection memory and reads the data memory.

Top module: `tsi_switch`

## Requirements
- R1: After reset the block is in `SEQ_HUNT`: `ser_oe` and `hiz_flag` are all 0 and no channel is processed. A `frame_pulse` high at a clock edge starts a frame whose cycle 0 follows that edge. The frame then runs for 512 cycles. A pulse during `SEQ_RUN` restarts the frame at cycle 0.
- R2: Reset sets every connection word to 14'h3000 (high-impedance mode). This is the value read back from every connection address before any write.
- R3: A connection word holds the mode in bits [13:12], a stream field in bits [11:8], and a channel or message byte in bits [7:0]. With mode 0 (switch), the output channel carries the byte that arrived in the previous frame on input stream [9:8], channel [5:0]. The byte is sent MSB first and `ser_oe` is 1.
- R4: With mode 1 (message), the output channel carries bits [7:0] of its own connection word, with `ser_oe` set to 1.
- R5: With mode 2 (pattern), the output channel carries the low byte of generator [9:8]. Generator g starts at 15'h7FFF-g. Each step shifts the state left and inserts bit14 XOR bit13. A generator takes 8 steps after each cycle in `SEQ_RUN` whose frame count is 15 modulo 16.
- R6: With mode 3 (high impedance), the channel has `ser_oe`=0 and `ser_out`=0. For streams below `HIZ_N`, `hiz_flag` is 1. It is 0 in every other mode.
- R7: Rate bit 1 means 64 channels at one bit per clock, so channel = count/8. Rate bit 0 means 32 channels with each bit held two clocks, so channel = count/16, and the input is sampled on odd counts. Each input stream and each output stream takes its own rate bit.
- R8: When `bidir[s]` is 1, the serial input of stream s is ignored and every channel it captures is stored as 8'hFF.
- R9: `cpu_en` with `cpu_wr` writes `cpu_wdata` to connection address {stream, channel} when `cpu_space`=0. Writes with `cpu_space`=1 are ignored. A read returns data on `cpu_rdata` one cycle later: the connection word, or {6'b0, byte} of the data memory half captured in the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock at the fast stream rate |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_pulse | input | 1 | Frame start marker; the next cycle is frame count 0 |
| ser_in | input | NSTREAM | Serial input streams |
| in_fast | input | NSTREAM | Per input stream rate: 1 fast, 0 slow |
| out_fast | input | NSTREAM | Per output stream rate: 1 fast, 0 slow |
| bidir | input | NSTREAM | Per stream: ignore the input, capture 8'hFF |
| cpu_en | input | 1 | Register port access strobe |
| cpu_wr | input | 1 | 1 write, 0 read |
| cpu_space | input | 1 | 0 connection memory, 1 data memory |
| cpu_addr | input | SW+6 | {stream, channel} |
| cpu_wdata | input | 14 | Connection word to write |
| ser_out | output | NSTREAM | Serial output streams |
| ser_oe | output | NSTREAM | Per stream drive enable for the current channel |
| hiz_flag | output | HIZ_N | High-impedance indication for the low streams |
| cpu_rdata | output | 14 | Read data, one cycle after the request |

## Verification
The hardest case to reach is an output that switches from an input stream running at the other rate while that source is also in bidirectional mode. It must come out a frame later, mapped to the right slow or fast channel. The bench first builds a directed configuration that cycles all four modes across channels and walks the source stream, including a bidirectional one. It then applies two random reconfigurations of rates, bidirectional bits and all 256 connection words, and checks every output bit of every cycle against a model of the previous frame's input.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int CM_W = 14;

    typedef enum logic [1:0] {
        CM_SWITCH   = 2'd0,
        CM_MESSAGE  = 2'd1,
        CM_PRBS     = 2'd2,
        CM_TRISTATE = 2'd3
    } cm_mode_e;

    typedef enum logic {
        SEQ_HUNT = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    function automatic logic [14:0] prbs_step8(input logic [14:0] s);
        logic [14:0] v;
        v = s;
        for (int i = 0; i < 8; i++) begin
            v = {v[13:0], v[14] ^ v[13]};
        end
        return v;
    endfunction

endpackage

// File: rtl/tsi_frame_seq.sv
module tsi_frame_seq
    import tsi_pkg::*;
#(
    parameter int FRAME_CYC = 512,
    parameter int CNT_W     = $clog2(FRAME_CYC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_pulse,
    output seq_state_e       state,
    output logic [CNT_W-1:0] cnt,
    output logic             parity
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CYC - 1);

    seq_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_HUNT: if (frame_pulse) state_nx = SEQ_RUN;
            SEQ_RUN:  state_nx = SEQ_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_HUNT;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            parity <= 1'b0;
        end else begin
            unique case (state)
                SEQ_HUNT: begin
                    cnt    <= '0;
                    parity <= 1'b0;
                end
                SEQ_RUN: begin
                    if (frame_pulse || cnt == LAST) begin
                        cnt    <= '0;
                        parity <= ~parity;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_RUN && !frame_pulse && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

    assert_frame_flip_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_RUN && (frame_pulse || cnt == LAST)) |=> (cnt == '0 && parity != $past(parity)));

    assert_hunt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_HUNT && !frame_pulse) |=> (state == SEQ_HUNT && cnt == '0));

endmodule

// File: rtl/tsi_prbs_bank.sv
module tsi_prbs_bank
    import tsi_pkg::*;
#(
    parameter int NGEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [NGEN*8-1:0] bytes_o
);

    for (genvar g = 0; g < NGEN; g++) begin : g_gen
        logic [14:0] st;

        always_ff @(posedge clk) begin
            if (!rst_n)       st <= 15'h7FFF - 15'(g);
            else if (advance) st <= prbs_step8(st);
        end

        assign bytes_o[g*8 +: 8] = st[7:0];

        assert_gen_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
            st != 15'd0);

        assert_gen_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
            advance |=> (st != $past(st)));
    end

endmodule

// File: rtl/tsi_tx_lane.sv
module tsi_tx_lane
    import tsi_pkg::*;
#(
    parameter int CH_W  = 6,
    parameter int SW    = 2,
    parameter int GSW   = 2,
    parameter int NGEN  = 4,
    parameter int CNT_W = CH_W + 3
) (
    input  seq_state_e        state,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              fast,
    input  logic [CM_W-1:0]   word,
    input  logic [7:0]        src_byte,
    input  logic [NGEN*8-1:0] prbs_bytes,
    output logic [CH_W-1:0]   slot,
    output logic [SW-1:0]     src_stream,
    output logic [CH_W-1:0]   src_chan,
    output logic              ser,
    output logic              oe,
    output logic              hz
);

    cm_mode_e       mode;
    logic [2:0]     bit_sel;
    logic [7:0]     chan_byte;
    logic [GSW-1:0] gen_sel;
    logic           unused_hi;

    assign unused_hi = ^word[11:8];

    always_comb begin
        slot       = fast ? cnt[CNT_W-1:3] : {1'b0, cnt[CNT_W-1:4]};
        bit_sel    = fast ? ~cnt[2:0] : ~cnt[3:1];
        mode       = cm_mode_e'(word[13:12]);
        src_stream = word[8 +: SW];
        src_chan   = word[CH_W-1:0];
        gen_sel    = word[8 +: GSW];
        chan_byte  = '0;
        oe         = 1'b0;
        hz         = 1'b0;
        if (state == SEQ_RUN) begin
            unique case (mode)
                CM_SWITCH: begin
                    chan_byte = src_byte;
                    oe        = 1'b1;
                end
                CM_MESSAGE: begin
                    chan_byte = word[7:0];
                    oe        = 1'b1;
                end
                CM_PRBS: begin
                    chan_byte = prbs_bytes[{gen_sel, 3'b000} +: 8];
                    oe        = 1'b1;
                end
                CM_TRISTATE: hz = 1'b1;
            endcase
        end
        ser = oe & chan_byte[bit_sel];
    end

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int NSTREAM = 4,
    parameter int HIZ_N   = 2,
    parameter int SW      = $clog2(NSTREAM),
    parameter int AW      = SW + 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_pulse,
    input  logic [NSTREAM-1:0] ser_in,
    input  logic [NSTREAM-1:0] in_fast,
    input  logic [NSTREAM-1:0] out_fast,
    input  logic [NSTREAM-1:0] bidir,
    input  logic               cpu_en,
    input  logic               cpu_wr,
    input  logic               cpu_space,
    input  logic [AW-1:0]      cpu_addr,
    input  logic [CM_W-1:0]    cpu_wdata,
    output logic [NSTREAM-1:0] ser_out,
    output logic [NSTREAM-1:0] ser_oe,
    output logic [HIZ_N-1:0]   hiz_flag,
    output logic [CM_W-1:0]    cpu_rdata
);

    localparam int CH_W    = 6;
    localparam int CNT_W   = CH_W + 3;
    localparam int FRAME   = 1 << CNT_W;
    localparam int CM_DEP  = NSTREAM << CH_W;
    localparam int DM_DEP  = 2 * CM_DEP;

    seq_state_e       seq_state;
    logic [CNT_W-1:0] cnt;
    logic             parity;
    logic             run;
    logic [NSTREAM*8-1:0] prbs_bytes;

    logic [CM_W-1:0] cmem [CM_DEP];
    logic [7:0]      dmem [DM_DEP];

    logic [6:0]      rx_sh   [NSTREAM];
    logic [7:0]      rx_byte [NSTREAM];
    logic [CH_W-1:0] rx_chan [NSTREAM];
    logic [NSTREAM-1:0] rx_take, rx_done;

    logic [CH_W-1:0] lane_slot   [NSTREAM];
    logic [SW-1:0]   lane_sstrm  [NSTREAM];
    logic [CH_W-1:0] lane_schan  [NSTREAM];
    logic [CM_W-1:0] lane_word   [NSTREAM];
    logic [7:0]      lane_src    [NSTREAM];
    logic [NSTREAM-1:0] lane_hz;

    tsi_frame_seq #(.FRAME_CYC(FRAME), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
        .state(seq_state), .cnt(cnt), .parity(parity)
    );

    assign run = (seq_state == SEQ_RUN);

    tsi_prbs_bank #(.NGEN(NSTREAM)) u_prbs (
        .clk(clk), .rst_n(rst_n), .advance(run && cnt[3:0] == 4'hF),
        .bytes_o(prbs_bytes)
    );

    // Input capture: per-stream rate and bidirectional fill (R7, R8)
    always_comb begin
        for (int s = 0; s < NSTREAM; s++) begin
            rx_take[s] = in_fast[s] | cnt[0];
            rx_done[s] = in_fast[s] ? (cnt[2:0] == 3'b111) : (cnt[3:0] == 4'hF);
            rx_chan[s] = in_fast[s] ? cnt[CNT_W-1:3] : {1'b0, cnt[CNT_W-1:4]};
            rx_byte[s] = bidir[s] ? 8'hFF : {rx_sh[s], ser_in[s]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSTREAM; s++) rx_sh[s] <= '0;
        end else begin
            for (int s = 0; s < NSTREAM; s++)
                if (run && rx_take[s]) rx_sh[s] <= {rx_sh[s][5:0], ser_in[s]};
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < NSTREAM; s++)
            if (run && rx_done[s]) dmem[{parity, SW'(s), rx_chan[s]}] <= rx_byte[s];
    end

    // Connection memory and register port (R2, R9)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CM_DEP; i++) cmem[i] <= {CM_TRISTATE, 12'h000};
            cpu_rdata <= '0;
        end else begin
            if (cpu_en && cpu_wr && !cpu_space) cmem[cpu_addr] <= cpu_wdata;
            if (cpu_en && !cpu_wr)
                cpu_rdata <= cpu_space ? {6'b0, dmem[{~parity, cpu_addr}]} : cmem[cpu_addr];
        end
    end

    // Output lanes
    always_comb begin
        for (int s = 0; s < NSTREAM; s++) begin
            lane_word[s] = cmem[{SW'(s), lane_slot[s]}];
            lane_src[s]  = dmem[{~parity, lane_sstrm[s], lane_schan[s]}];
        end
    end

    for (genvar s = 0; s < NSTREAM; s++) begin : g_lane
        tsi_tx_lane #(.CH_W(CH_W), .SW(SW), .GSW(SW), .NGEN(NSTREAM), .CNT_W(CNT_W)) u_lane (
            .state(seq_state), .cnt(cnt), .fast(out_fast[s]), .word(lane_word[s]),
            .src_byte(lane_src[s]), .prbs_bytes(prbs_bytes),
            .slot(lane_slot[s]), .src_stream(lane_sstrm[s]), .src_chan(lane_schan[s]),
            .ser(ser_out[s]), .oe(ser_oe[s]), .hz(lane_hz[s])
        );

        assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !ser_oe[s] |-> !ser_out[s]);
    end

    for (genvar h = 0; h < HIZ_N; h++) begin : g_hz
        assign hiz_flag[h] = lane_hz[h];

        assert_hz_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
            hiz_flag[h] |-> !ser_oe[h]);
    end

    assert_hunt_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_HUNT) |-> (ser_oe == '0 && hiz_flag == '0));

    assert_write_then_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cpu_en && cpu_wr && !cpu_space) && cpu_en && !cpu_wr && !cpu_space
         && cpu_addr == $past(cpu_addr)) |=> (cpu_rdata == $past(cpu_wdata, 2)));

endmodule

// File: tb/tsi_switch_test.sv
module tsi_switch_test;
    import tsi_pkg::*;

    localparam int NS  = 4;
    localparam int HZN = 2;
    localparam int NF  = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_pulse = 1'b0;
    logic [NS-1:0] ser_in = '0, in_fast = '0, out_fast = '0, bidir = '0;
    logic cpu_en = 1'b0, cpu_wr = 1'b0, cpu_space = 1'b0;
    logic [7:0] cpu_addr = '0;
    logic [13:0] cpu_wdata = '0;
    logic [NS-1:0] ser_out, ser_oe;
    logic [HZN-1:0] hiz_flag;
    logic [13:0] cpu_rdata;

    tsi_switch #(.NSTREAM(NS), .HIZ_N(HZN)) uut (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .ser_in(ser_in),
        .in_fast(in_fast), .out_fast(out_fast), .bidir(bidir),
        .cpu_en(cpu_en), .cpu_wr(cpu_wr), .cpu_space(cpu_space), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .ser_out(ser_out), .ser_oe(ser_oe), .hiz_flag(hiz_flag),
        .cpu_rdata(cpu_rdata)
    );

    always #10 clk = ~clk;

    logic [7:0]  tb_in  [NF][NS][64];
    logic [13:0] tb_cm  [NS][64];
    logic [14:0] tb_gen [NS];
    int n_chk = 0, n_fail = 0;
    int cur_f = 0, cur_k = 0, valid_from = 1;
    bit running = 1'b0, done_run = 1'b0, finished = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [14:0] lfsr8(input logic [14:0] s);
        logic [14:0] v = s;
        for (int i = 0; i < 8; i++) v = {v[13:0], v[14] ^ v[13]};
        return v;
    endfunction

    task automatic cpu_write(input bit space, input logic [7:0] a, input logic [13:0] d);
        @(negedge clk);
        cpu_en = 1'b1; cpu_wr = 1'b1; cpu_space = space; cpu_addr = a; cpu_wdata = d;
        if (!space) tb_cm[a[7:6]][a[5:0]] = d;
        @(negedge clk);
        cpu_en = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input bit space, input logic [7:0] a, output logic [13:0] d);
        @(negedge clk);
        cpu_en = 1'b1; cpu_wr = 1'b0; cpu_space = space; cpu_addr = a;
        @(negedge clk);
        cpu_en = 1'b0;
        d = cpu_rdata;
    endtask

    // random connection set consistent with current input rates
    task automatic random_config();
        in_fast  = NS'($urandom);
        out_fast = NS'($urandom);
        bidir    = NS'($urandom);
        for (int s = 0; s < NS; s++) begin
            for (int c = 0; c < 64; c++) begin
                logic [1:0] m = 2'($urandom);
                logic [1:0] src = 2'($urandom);
                logic [5:0] sc = in_fast[src] ? 6'($urandom) : {1'b0, 5'($urandom)};
                logic [13:0] w;
                if (m == 2'd1) w = {2'd1, 4'($urandom), 8'($urandom)};
                else           w = {m, 2'b00, src, 2'b00, sc};
                cpu_write(1'b0, {2'(s), 6'(c)}, w);
            end
        end
    endtask

    // expected output per cycle
    task automatic check_outputs(input int f, input int k);
        for (int s = 0; s < NS; s++) begin
            bit fast = out_fast[s];
            int ch = fast ? (k >> 3) : (k >> 4);
            int b  = fast ? 7 - (k & 7) : 7 - ((k >> 1) & 7);
            logic [13:0] w = tb_cm[s][ch];
            logic [7:0] by = 8'h00;
            logic [2:0] exp_v, act_v;
            string tag;
            bit hz_exp = 1'b0, oe_exp = 1'b1;
            case (w[13:12])
                2'd0: begin
                    int src = w[9:8];
                    by  = bidir[src] ? 8'hFF : tb_in[f-1][src][w[5:0]];
                    tag = "R3 switch";
                    if (bidir[src]) tag = {tag, " R8 bidir"};
                    if (!fast || !in_fast[src]) tag = {tag, " R7 slow"};
                end
                2'd1: begin by = w[7:0]; tag = "R4 message"; end
                2'd2: begin by = tb_gen[w[9:8]][7:0]; tag = "R5 pattern"; end
                default: begin oe_exp = 1'b0; hz_exp = (s < HZN); tag = "R6 tristate"; end
            endcase
            if (!fast && w[13:12] != 2'd0) tag = {tag, " R7 slow"};
            exp_v = {oe_exp & by[b], oe_exp, hz_exp};
            act_v = {ser_out[s], ser_oe[s], (s < HZN) ? hiz_flag[s % HZN] : 1'b0};
            check(act_v == exp_v, $sformatf("%s s%0d f%0d k%0d", tag, s, f, k), act_v, exp_v);
        end
    endtask

    // frame driver
    initial begin
        for (int g = 0; g < NS; g++) tb_gen[g] = 15'h7FFF - 15'(g);
        wait (running);
        for (int f = 0; f < NF; f++) begin
            cur_f = f;
            for (int s = 0; s < NS; s++)
                for (int c = 0; c < 64; c++) tb_in[f][s][c] = 8'($urandom);
            for (int k = 0; k < 512; k++) begin
                @(negedge clk);
                cur_k = k;
                if (f >= valid_from) check_outputs(f, k);
                for (int s = 0; s < NS; s++)
                    ser_in[s] = in_fast[s] ? tb_in[f][s][k >> 3][7 - (k & 7)]
                                           : tb_in[f][s][k >> 4][7 - ((k >> 1) & 7)];
                frame_pulse = (k == 511);
                if ((k & 15) == 15)
                    for (int g = 0; g < NS; g++) tb_gen[g] = lfsr8(tb_gen[g]);
            end
        end
        done_run = 1'b1;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [13:0] rd;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        check(ser_oe == '0 && hiz_flag == '0, "R1 reset outputs idle", {ser_oe, hiz_flag}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(ser_oe == '0 && hiz_flag == '0, "R1 hunt outputs idle", {ser_oe, hiz_flag}, 0);

        cpu_read(1'b0, 8'h00, rd);
        check(rd == 14'h3000, "R2 reset word addr 00", rd, 14'h3000);
        cpu_read(1'b0, 8'hFF, rd);
        check(rd == 14'h3000, "R2 reset word addr FF", rd, 14'h3000);
        cpu_read(1'b0, 8'h5A, rd);
        check(rd == 14'h3000, "R2 reset word addr 5A", rd, 14'h3000);

        // directed session: all four modes, mixed rates, one bidir source
        in_fast = 4'b0101; out_fast = 4'b0011; bidir = 4'b1000;
        for (int s = 0; s < NS; s++) begin
            for (int c = 0; c < 64; c++) begin
                logic [1:0] src = 2'((c / 4 + s) % 4);
                logic [5:0] sc  = in_fast[src] ? 6'(63 - c) : 6'(c % 32);
                logic [13:0] w;
                case (c % 4)
                    0: w = {2'd0, 2'b00, src, 2'b00, sc};
                    1: w = {2'd1, 4'h0, 8'(c * 7 + s * 29)};
                    2: w = {2'd2, 2'b00, 2'((s + c) % 4), 8'h00};
                    default: w = {2'd3, 12'h000};
                endcase
                cpu_write(1'b0, {2'(s), 6'(c)}, w);
            end
        end
        cpu_write(1'b0, 8'h41, 14'h1C3);
        cpu_read(1'b0, 8'h41, rd);
        check(rd == 14'h1C3, "R9 connection readback", rd, 14'h1C3);
        cpu_write(1'b0, 8'h41, {2'd1, 4'h0, 8'hA5});

        check(ser_oe == '0, "R1 still hunting before pulse", ser_oe, 0);
        @(negedge clk);
        frame_pulse = 1'b1;
        valid_from = 1;
        running = 1'b1;

        wait (cur_f == 3 && cur_k == 100);
        cpu_write(1'b1, 8'h45, 14'h00AA);
        cpu_read(1'b1, 8'h45, rd);
        check(rd == {6'b0, tb_in[2][1][5]}, "R9 data read stream1 ch5 (write ignored)", rd, tb_in[2][1][5]);
        cpu_read(1'b1, 8'h3C, rd);
        check(rd == {6'b0, tb_in[2][0][60]}, "R9 data read stream0 ch60", rd, tb_in[2][0][60]);
        cpu_read(1'b1, 8'hC7, rd);
        check(rd == 14'h00FF, "R8 bidir stream captured as FF", rd, 14'h00FF);

        wait (cur_f == 4);
        valid_from = 1000;
        random_config();
        valid_from = cur_f + 2;

        wait (cur_f == 9);
        valid_from = 1000;
        random_config();
        valid_from = cur_f + 2;

        wait (done_run);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule